// File: doc/BRIEF.md
# Host Command FIFO with Retry

This block is the front end that takes 32-bit host writes and turns them into command entries for a downstream consumer. Each entry pairs a register tag with a 32-bit data word, and the tag selects the register the consumer updates. Entries come in three ways. The host can write a register's mapped address. The host can send a tag word and then a data word through a FIFO window. A DMA feeder can move a counted run of tag/data words from a source stream.

The host can poll a read-only count of free entries before it writes. A control bit selects what happens when the host writes to a full queue. With the bit clear, the write is dropped and a saturating drop counter counts it. With the bit set, the write is refused with a retry signal on every cycle until space frees, and then it is accepted. The DMA feeder only moves a word when a slot is free, and the host wins any slot it contends for.

Top module: `host_cmd_fifo`

## Requirements
- R1: A host write to any address with bit 15 set pushes one entry whose tag is address bits [11:2] and whose data is the write data.
- R2: The first write to address 0x2000 stores write-data bits [9:0] as a pending tag and pushes nothing. The next write to 0x2000 pushes that tag with its write data. The pair after that starts again with a tag word.
- R3: A read of address 0x0018 returns the queue depth (default 16) minus the occupancy. The value changes in the cycle after a push or pop. It reads 16 after reset.
- R4: Bit 0 of the control word at address 0x0068 enables retry mode. It reads back at bit 0, and it is 0 after reset.
- R5: With retry mode off, a push-type write while the queue is full and not popping is lost, host_retry_o stays 0, and the drop counter increases by one.
- R6: With retry mode on, such a write holds host_retry_o high in every cycle the queue stays full. It is accepted in the first cycle a slot frees, and nothing is dropped.
- R7: A read of address 0x001C returns the drop count (8-bit, saturating at 255), and the read clears it.
- R8: A DMA start with length N moves exactly N source words into the queue, only while a slot exists, and never overflows. dma_busy_o is high from the cycle after start until the last word is taken.
- R9: When a host push and a DMA word contend for the same cycle, the host entry enters the queue first and the DMA word follows one cycle later.
- R10: On a full queue, a push and a pop in the same cycle both succeed and the occupancy stays at full.
- R11: Entries leave on the out port in arrival order. out_valid_o is high whenever the queue is non-empty, and an entry is popped when out_valid_o and out_ready_i are both high.
- R12: After reset the queue is empty, out_valid_o is 0, host_retry_o is 0 and dma_busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 16 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, valid during the read cycle |
| host_retry_o | output | 1 | Write refused, retry |
| dma_start_i | input | 1 | Start a DMA run |
| dma_len_i | input | 17 | DMA word count (up to 65536) |
| dma_busy_o | output | 1 | DMA run in progress |
| dma_valid_i | input | 1 | Source word valid |
| dma_tag_i | input | 10 | Source word tag |
| dma_data_i | input | 32 | Source word data |
| dma_ready_o | output | 1 | Source word taken this cycle if valid |
| out_valid_o | output | 1 | Queue head valid |
| out_tag_o | output | 10 | Queue head tag |
| out_data_o | output | 32 | Queue head data |
| out_ready_i | input | 1 | Consumer takes head |

## Verification
The queue is driven by single mapped writes, by tag/data window pairs, by DMA runs that drain freely, and by DMA runs that stall against a full queue. Comparing these shows whether the tag comes from the address or from the pending window word, and whether the DMA feeder respects back-pressure. Overfill is tried with retry mode off and with retry mode on. The drop counter and the free count together separate a lost write from one that was held and later accepted. A retry that resolves in the same cycle as a pop tests the push-and-pop on full case. A host write timed against a DMA word shows the arbitration order.

// File: rtl/host_fifo_pkg.sv
package host_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 10;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 17;
  localparam int DROP_W = 8;

  localparam logic [ADDR_W-1:0] ADR_FREE = 16'h0018;
  localparam logic [ADDR_W-1:0] ADR_DROP = 16'h001C;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 16'h0068;
  localparam logic [ADDR_W-1:0] ADR_WIN  = 16'h2000;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo
  import host_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  cmd_t          din_i,
  input  logic          pop_i,
  output cmd_t          dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  cmd_t          mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (count_o == $past(count_o) + 1'b1));
  assert_full_pushpop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full_o) |=> full_o);
endmodule

// File: rtl/host_regs.sv
module host_regs
  import host_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              can_push_i,
  input  logic [CW-1:0]     count_i,
  output logic              want_o,
  output logic              push_o,
  output cmd_t              entry_o,
  output logic              retry_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic              retry_en_q, half_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DROP_W-1:0] drop_q;
  logic              is_reg, is_win, drop, clr;

  assign is_reg = addr_i[ADDR_W-1];
  assign is_win = (addr_i == ADR_WIN);
  assign want_o = wr_i && (is_reg || (is_win && half_q));

  assign entry_o.tag  = is_reg ? addr_i[TAG_W+1:2] : tag_q;
  assign entry_o.data = wdata_i;

  assign push_o  = want_o && can_push_i;
  assign retry_o = want_o && !can_push_i && retry_en_q;
  assign drop    = want_o && !can_push_i && !retry_en_q;
  assign clr     = rd_i && (addr_i == ADR_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_en_q <= 1'b0;
      half_q     <= 1'b0;
      tag_q      <= '0;
      drop_q     <= '0;
    end else begin
      if (wr_i && addr_i == ADR_CTRL) retry_en_q <= wdata_i[0];
      if (wr_i && is_win) begin
        if (!half_q) begin
          half_q <= 1'b1;
          tag_q  <= wdata_i[TAG_W-1:0];
        end else if (!retry_o) begin
          half_q <= 1'b0;  // accepted or dropped
        end
      end
      if (clr)                          drop_q <= DROP_W'(drop);
      else if (drop && drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADR_FREE: rdata_o = DATA_W'(DEPTH) - DATA_W'(count_i);
        ADR_DROP: rdata_o = DATA_W'(drop_q);
        ADR_CTRL: rdata_o = DATA_W'(retry_en_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_drop_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !clr && drop_q != DROP_MAX) |=> (drop_q == $past(drop_q) + 1'b1));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !drop) |=> (drop_q == '0));
  assert_ctrl_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_CTRL) |=> (retry_en_q == $past(wdata_i[0])));
endmodule

// File: rtl/dma_feeder.sv
module dma_feeder
  import host_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  input  logic             slot_i,
  input  logic             src_valid_i,
  input  logic [TAG_W-1:0] src_tag_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic             src_ready_o,
  output logic             push_o,
  output cmd_t             entry_o
);
  logic [LEN_W-1:0] rem_q;

  assign busy_o        = (rem_q != '0);
  assign src_ready_o   = busy_o && slot_i;
  assign push_o        = src_ready_o && src_valid_i;
  assign entry_o.tag   = src_tag_i;
  assign entry_o.data  = src_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rem_q <= '0;
    else if (start_i && !busy_o) rem_q <= len_i;
    else if (push_o)          rem_q <= rem_q - 1'b1;
  end

  assert_start_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (rem_q == $past(len_i)));
  assert_word_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !start_i) |=> (rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/host_cmd_fifo.sv
module host_cmd_fifo
  import host_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_retry_o,
  input  logic              dma_start_i,
  input  logic [LEN_W-1:0]  dma_len_i,
  output logic              dma_busy_o,
  input  logic              dma_valid_i,
  input  logic [TAG_W-1:0]  dma_tag_i,
  input  logic [DATA_W-1:0] dma_data_i,
  output logic              dma_ready_o,
  output logic              out_valid_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic          pop, can_push, full, empty;
  logic          h_want, h_push, d_push, push;
  logic [CW-1:0] count;
  cmd_t          h_entry, d_entry, din, dout;

  assign pop      = out_ready_i && !empty;
  assign can_push = !full || pop;  // a pop frees the slot in the same cycle
  assign push     = h_push || d_push;
  assign din      = h_push ? h_entry : d_entry;

  host_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .rd_i(host_rd_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .can_push_i(can_push), .count_i(count),
    .want_o(h_want), .push_o(h_push), .entry_o(h_entry),
    .retry_o(host_retry_o), .rdata_o(host_rdata_o)
  );

  dma_feeder u_dma (
    .clk_i, .rst_ni,
    .start_i(dma_start_i), .len_i(dma_len_i), .busy_o(dma_busy_o),
    .slot_i(can_push && !h_want),
    .src_valid_i(dma_valid_i), .src_tag_i(dma_tag_i), .src_data_i(dma_data_i),
    .src_ready_o(dma_ready_o), .push_o(d_push), .entry_o(d_entry)
  );

  cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(din), .pop_i(pop),
    .dout_o(dout), .count_o(count), .full_o(full), .empty_o(empty)
  );

  assign out_valid_o = !empty;
  assign out_tag_o   = dout.tag;
  assign out_data_o  = dout.data;

  assert_host_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h_push && d_push));
  assert_retry_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_retry_o |-> (count == CW'(DEPTH) && !out_ready_i));
  assert_valid_tracks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop) |=> out_valid_o);
endmodule

// File: tb/host_cmd_fifo_bench.sv
module host_cmd_fifo_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        host_wr_i = 0, host_rd_i = 0;
  logic [15:0] host_addr_i = '0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic        host_retry_o;
  logic        dma_start_i = 0;
  logic [16:0] dma_len_i = '0;
  logic        dma_busy_o, dma_valid_i = 1'b1, dma_ready_o;
  logic [9:0]  dma_tag_i;
  logic [31:0] dma_data_i;
  logic        out_valid_o, out_ready_i = 0;
  logic [9:0]  out_tag_o;
  logic [31:0] out_data_o;

  int n_chk = 0, n_fail = 0;
  int src_idx = 0;
  int rx_n = 0;
  logic [9:0]  rx_tag  [64];
  logic [31:0] rx_data [64];

  always #2.5 clk_i = ~clk_i;

  host_cmd_fifo u_host_cmd_fifo (.*);

  assign dma_tag_i  = 10'(src_idx) + 10'h100;
  assign dma_data_i = 32'hD000_0000 | 32'(src_idx);

  always @(posedge clk_i) begin
    if (dma_valid_i && dma_ready_o) src_idx <= src_idx + 1;
    if (out_valid_o && out_ready_i) begin
      rx_tag[rx_n % 64]  <= out_tag_o;
      rx_data[rx_n % 64] <= out_data_o;
      rx_n <= rx_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk_i);
    host_wr_i = 1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i);
    host_wr_i = 0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk_i);
    host_rd_i = 1; host_addr_i = a;
    #1 v = host_rdata_o;
    @(negedge clk_i);
    host_rd_i = 0;
  endtask

  task automatic drain(input int n);
    @(negedge clk_i);
    out_ready_i = 1;
    repeat (n) @(negedge clk_i);
    out_ready_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R12 out_valid", 32'(out_valid_o), 0);
    chk("R12 retry", 32'(host_retry_o), 0);
    chk("R12 busy", 32'(dma_busy_o), 0);
    hrd(16'h0018, v); chk("R3 free after reset", v, 16);
    hrd(16'h0068, v); chk("R4 ctrl after reset", v, 0);
  endtask

  task automatic t_reg_write;
    logic [31:0] v;
    hwr(16'h8000 + 16'(4 * 5), 32'h1234_5678);
    chk("R11 valid", 32'(out_valid_o), 1);
    chk("R1 tag", 32'(out_tag_o), 5);
    chk("R1 data", out_data_o, 32'h1234_5678);
    hrd(16'h0018, v); chk("R3 free after push", v, 15);
    drain(1);
    hrd(16'h0018, v); chk("R3 free after pop", v, 16);
  endtask

  task automatic t_window;
    logic [31:0] v;
    hwr(16'h2000, 32'hFFFF_F3AB);
    hrd(16'h0018, v); chk("R2 tag word pushes nothing", v, 16);
    hwr(16'h2000, 32'hCAFE_0001);
    chk("R2 pair tag", 32'(out_tag_o), 32'h3AB);
    chk("R2 pair data", out_data_o, 32'hCAFE_0001);
    hwr(16'h2000, 32'h0000_0011);
    hwr(16'h2000, 32'hCAFE_0002);
    hrd(16'h0018, v); chk("R2 second pair", v, 14);
    drain(2);
    chk("R2 second tag", 32'(rx_tag[(rx_n - 1) % 64]), 32'h011);
  endtask

  task automatic fill16(input logic [31:0] base);
    for (int i = 0; i < 16; i++) hwr(16'h8000 + 16'(4 * i), base + 32'(i));
  endtask

  task automatic t_drop;
    logic [31:0] v;
    int b;
    fill16(32'h0000_1000);
    @(negedge clk_i);
    host_wr_i = 1; host_addr_i = 16'h8040; host_wdata_i = 32'hBAD0_0000;
    #1 chk("R5 no retry when off", 32'(host_retry_o), 0);
    @(negedge clk_i); host_wr_i = 0;
    hrd(16'h0018, v); chk("R5 still full", v, 0);
    hrd(16'h001C, v); chk("R7 drop count", v, 1);
    hrd(16'h001C, v); chk("R7 cleared by read", v, 0);
    b = rx_n;
    drain(16);
    chk("R5 only 16 out", 32'(rx_n - b), 16);
    chk("R11 first out", rx_data[b % 64], 32'h0000_1000);
    chk("R11 last out", rx_data[(b + 15) % 64], 32'h0000_100F);
  endtask

  task automatic t_retry;
    logic [31:0] v;
    int b;
    hwr(16'h0068, 32'h1);
    hrd(16'h0068, v); chk("R4 ctrl readback", v, 1);
    fill16(32'h0000_2000);
    @(negedge clk_i);
    host_wr_i = 1; host_addr_i = 16'h8044; host_wdata_i = 32'h5EE0_0001;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R6 retry while full", 32'(host_retry_o), 1);
      @(negedge clk_i);
    end
    out_ready_i = 1;
    #1 chk("R10 retry released by pop", 32'(host_retry_o), 0);
    @(negedge clk_i);
    host_wr_i = 0; out_ready_i = 0;
    hrd(16'h0018, v); chk("R10 full after push+pop", v, 0);
    hrd(16'h001C, v); chk("R6 nothing dropped", v, 0);
    b = rx_n;
    drain(16);
    chk("R6 retried write last", rx_data[(b + 15) % 64], 32'h5EE0_0001);
    chk("R6 retried tag", 32'(rx_tag[(b + 15) % 64]), 32'h011);
    hwr(16'h0068, 32'h0);
  endtask

  task automatic t_dma(input int len, input bit stall);
    logic [31:0] v;
    int b, s;
    b = rx_n; s = src_idx;
    out_ready_i = !stall;
    @(negedge clk_i);
    dma_start_i = 1; dma_len_i = 17'(len);
    @(negedge clk_i);
    dma_start_i = 0;
    chk("R8 busy after start", 32'(dma_busy_o), 1);
    repeat (len + 10) @(negedge clk_i);
    if (stall) begin
      hrd(16'h0018, v); chk("R8 stalls at full", v, 0);
      chk("R8 busy while stalled", 32'(dma_busy_o), 1);
      out_ready_i = 1;
      repeat (len + 10) @(negedge clk_i);
    end
    out_ready_i = 0;
    chk("R8 busy done", 32'(dma_busy_o), 0);
    chk("R8 word count", 32'(rx_n - b), 32'(len));
    chk("R8 first word", rx_data[b % 64], 32'hD000_0000 | 32'(s));
    chk("R8 last word", rx_data[(b + len - 1) % 64], 32'hD000_0000 | 32'(s + len - 1));
  endtask

  task automatic t_prio;
    logic [31:0] v;
    int b, s;
    b = rx_n; s = src_idx;
    @(negedge clk_i);
    dma_start_i = 1; dma_len_i = 17'd1;
    @(negedge clk_i);
    dma_start_i = 0;
    host_wr_i = 1; host_addr_i = 16'h801C; host_wdata_i = 32'hAAAA_0007;
    @(negedge clk_i);
    host_wr_i = 0;
    @(negedge clk_i);
    hrd(16'h0018, v); chk("R9 both entered", v, 14);
    drain(2);
    chk("R9 host first", rx_data[b % 64], 32'hAAAA_0007);
    chk("R9 dma second", rx_data[(b + 1) % 64], 32'hD000_0000 | 32'(s));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", n_chk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_reg_write();
    t_window();
    t_drop();
    t_retry();
    t_dma(5, 1'b0);
    t_dma(20, 1'b1);
    t_prio();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule